// File: doc/BRIEF.md
# Indexed Endpoint Control and Status Bank

This block keeps the control and status state of a small set of USB device endpoints and exposes it to software through a narrow register bus. Three shared addresses are not tied to any endpoint: they act on whichever endpoint number software last wrote into the selector register. Global registers hold per-endpoint interrupt enables and sticky pending bits, one bit per endpoint, kept apart for the IN and OUT directions.

The endpoint logic drives single-cycle strobes: one when an OUT packet has been received, which carries its byte count, and one when an IN FIFO becomes free. The bank then sets a ready flag, latches the count and records a pending interrupt. Software takes the packet out, by DMA or by reads, and then clears the ready flag to return the FIFO. A per-endpoint DMA enable bit is passed to the transfer logic. When this bit is 0, transfers run one packet at a time under software control instead of as a bulk stream.

The register bus has no back-pressure. Every write is accepted on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr` and the current state. The strobe inputs are also always accepted and cannot be stalled.

Top module: `ep_index_regs`

## Requirements
- R1: After reset, every register, every ready flag, every DMA enable, every latched count and `irq_o` is 0.
- R2: Address 0 holds a 4-bit endpoint selector that reads back as written. Addresses 5 (CSR1), 6 (CSR2) and 7 (COUNT) access the endpoint named by the selector.
- R3: When the selector holds 4 to 15, addresses 5, 6 and 7 read as 0, and writes to 5 and 6 change nothing.
- R4: A pulse on `out_rx_stb[i]` sets endpoint i's OUT ready flag (CSR1 bit 0, `out_rdy_o[i]`). It also latches `out_rx_len[7i+6:7i]` as the value that COUNT reads for endpoint i.
- R5: A write to CSR1 with bit 0 equal to 0 clears the OUT ready flag, and writing 1 there has no effect. If a receive strobe arrives in the same cycle as the clearing write, the flag ends up set.
- R6: The IN ready flag (CSR1 bit 1, `in_rdy_o[i]`) takes the value of bit 1 on every CSR1 write. A pulse on `in_free_stb[i]` clears it, and the strobe wins over a write in the same cycle.
- R7: CSR2 bit 0 is the endpoint's DMA enable. It reads back as written and drives `dma_en_o[i]`.
- R8: Address 3 holds the IN pending bits and address 4 the OUT pending bits, bit i for endpoint i. A pulse on `in_free_stb[i]` sets IN pending bit i, and a pulse on `out_rx_stb[i]` sets OUT pending bit i, whatever the enables hold. Pending bits stay set until software writes 1 to them; writing 0 leaves them unchanged. If a strobe and a clear hit the same bit in one cycle, the bit ends up set.
- R9: Addresses 1 (IN enables) and 2 (OUT enables) hold one bit per endpoint. `irq_o` is high exactly when some pending bit and its matching enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| out_rx_stb | input | 4 | OUT packet received, one bit per endpoint |
| out_rx_len | input | 28 | Received byte count, 7 bits per endpoint |
| in_free_stb | input | 4 | IN FIFO became free, one bit per endpoint |
| out_rdy_o | output | 4 | OUT ready flags |
| in_rdy_o | output | 4 | IN ready flags |
| dma_en_o | output | 4 | DMA enable bits |
| irq_o | output | 1 | Interrupt request |

## Verification
Some cases can only be reached when a hardware strobe and a software write land on the same edge. These are a receive against a clearing CSR1 write, a free strobe against an IN ready write, and a strobe against a write-one-to-clear of its own pending bit. The bench drives each pair in one shared cycle and checks that the set from hardware wins. The selector's unused range is swept in full: all twelve out-of-range values are written and then followed by writes to CSR1 and CSR2. A walk over every selector value then confirms that no endpoint was changed.

// File: rtl/ep_regs_pkg.sv
package ep_regs_pkg;

  typedef enum logic [2:0] {
    A_INDEX  = 3'd0,
    A_IN_EN  = 3'd1,
    A_OUT_EN = 3'd2,
    A_IN_ST  = 3'd3,
    A_OUT_ST = 3'd4,
    A_CSR1   = 3'd5,
    A_CSR2   = 3'd6,
    A_COUNT  = 3'd7
  } reg_addr_e;

  localparam int B_OUT_RDY = 0;
  localparam int B_IN_RDY  = 1;
  localparam int B_DMA_EN  = 0;

endpackage

// File: rtl/ep_slot.sv
module ep_slot #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             csr1_we,
  input  logic             csr2_we,
  input  logic             wr_out_rdy,
  input  logic             wr_in_rdy,
  input  logic             wr_dma_en,
  input  logic             rx_stb,
  input  logic [CNT_W-1:0] rx_len,
  input  logic             free_stb,
  output logic             out_rdy,
  output logic             in_rdy,
  output logic             dma_en,
  output logic [CNT_W-1:0] rx_count
);

  logic hit1, hit2;
  assign hit1 = sel && csr1_we;
  assign hit2 = sel && csr2_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_rdy  <= 1'b0;
      in_rdy   <= 1'b0;
      dma_en   <= 1'b0;
      rx_count <= '0;
    end else begin
      if (rx_stb)                out_rdy <= 1'b1;
      else if (hit1 && !wr_out_rdy) out_rdy <= 1'b0;

      if (free_stb)  in_rdy <= 1'b0;
      else if (hit1) in_rdy <= wr_in_rdy;

      if (hit2)   dma_en   <= wr_dma_en;
      if (rx_stb) rx_count <= rx_len;
    end
  end

endmodule

// File: rtl/ep_irq_ctrl.sv
module ep_irq_ctrl #(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_en_we,
  input  logic              out_en_we,
  input  logic              in_st_we,
  input  logic              out_st_we,
  input  logic [NUM_EP-1:0] wdata,
  input  logic [NUM_EP-1:0] in_evt,
  input  logic [NUM_EP-1:0] out_evt,
  output logic [NUM_EP-1:0] in_en,
  output logic [NUM_EP-1:0] out_en,
  output logic [NUM_EP-1:0] in_st,
  output logic [NUM_EP-1:0] out_st,
  output logic              irq
);

  logic [NUM_EP-1:0] in_clr, out_clr;
  assign in_clr  = in_st_we  ? wdata : '0;
  assign out_clr = out_st_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_en  <= '0;
      out_en <= '0;
      in_st  <= '0;
      out_st <= '0;
    end else begin
      if (in_en_we)  in_en  <= wdata;
      if (out_en_we) out_en <= wdata;
      in_st  <= (in_st  & ~in_clr)  | in_evt;
      out_st <= (out_st & ~out_clr) | out_evt;
    end
  end

  assign irq = |(in_st & in_en) | |(out_st & out_en);

endmodule

// File: rtl/ep_index_regs.sv
module ep_index_regs
  import ep_regs_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int IDX_W  = 4,
  parameter int DW     = 8,
  parameter int CNT_W  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              bus_addr,
  input  logic                    bus_we,
  input  logic [DW-1:0]           bus_wdata,
  output logic [DW-1:0]           bus_rdata,
  input  logic [NUM_EP-1:0]       out_rx_stb,
  input  logic [NUM_EP*CNT_W-1:0] out_rx_len,
  input  logic [NUM_EP-1:0]       in_free_stb,
  output logic [NUM_EP-1:0]       out_rdy_o,
  output logic [NUM_EP-1:0]       in_rdy_o,
  output logic [NUM_EP-1:0]       dma_en_o,
  output logic                    irq_o
);

  reg_addr_e         a;
  logic [IDX_W-1:0]  idx_q;
  logic              idx_ok;
  logic [NUM_EP-1:0] slot_sel;
  logic [NUM_EP-1:0] in_en, out_en, in_st, out_st;
  logic [CNT_W-1:0]  rx_count [NUM_EP];
  logic              unused_wdata;

  assign a            = reg_addr_e'(bus_addr);
  assign idx_ok       = 32'(idx_q) < NUM_EP;
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       idx_q <= '0;
    else if (bus_we && a == A_INDEX)  idx_q <= bus_wdata[IDX_W-1:0];
  end

  for (genvar i = 0; i < NUM_EP; i++) begin : g_slot
    assign slot_sel[i] = idx_ok && (32'(idx_q) == i);

    ep_slot #(.CNT_W(CNT_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (slot_sel[i]),
      .csr1_we    (bus_we && a == A_CSR1),
      .csr2_we    (bus_we && a == A_CSR2),
      .wr_out_rdy (bus_wdata[B_OUT_RDY]),
      .wr_in_rdy  (bus_wdata[B_IN_RDY]),
      .wr_dma_en  (bus_wdata[B_DMA_EN]),
      .rx_stb     (out_rx_stb[i]),
      .rx_len     (out_rx_len[i*CNT_W +: CNT_W]),
      .free_stb   (in_free_stb[i]),
      .out_rdy    (out_rdy_o[i]),
      .in_rdy     (in_rdy_o[i]),
      .dma_en     (dma_en_o[i]),
      .rx_count   (rx_count[i])
    );
  end

  ep_irq_ctrl #(.NUM_EP(NUM_EP)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_en_we  (bus_we && a == A_IN_EN),
    .out_en_we (bus_we && a == A_OUT_EN),
    .in_st_we  (bus_we && a == A_IN_ST),
    .out_st_we (bus_we && a == A_OUT_ST),
    .wdata     (bus_wdata[NUM_EP-1:0]),
    .in_evt    (in_free_stb),
    .out_evt   (out_rx_stb),
    .in_en     (in_en),
    .out_en    (out_en),
    .in_st     (in_st),
    .out_st    (out_st),
    .irq       (irq_o)
  );

  logic             sel_out, sel_in, sel_dma;
  logic [CNT_W-1:0] sel_cnt;

  always_comb begin
    sel_out = 1'b0;
    sel_in  = 1'b0;
    sel_dma = 1'b0;
    sel_cnt = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (slot_sel[i]) begin
        sel_out = out_rdy_o[i];
        sel_in  = in_rdy_o[i];
        sel_dma = dma_en_o[i];
        sel_cnt = rx_count[i];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (a)
      A_INDEX:  bus_rdata[IDX_W-1:0]  = idx_q;
      A_IN_EN:  bus_rdata[NUM_EP-1:0] = in_en;
      A_OUT_EN: bus_rdata[NUM_EP-1:0] = out_en;
      A_IN_ST:  bus_rdata[NUM_EP-1:0] = in_st;
      A_OUT_ST: bus_rdata[NUM_EP-1:0] = out_st;
      A_CSR1: begin
        bus_rdata[B_OUT_RDY] = sel_out;
        bus_rdata[B_IN_RDY]  = sel_in;
      end
      A_CSR2:   bus_rdata[B_DMA_EN]    = sel_dma;
      A_COUNT:  bus_rdata[CNT_W-1:0]   = sel_cnt;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ep_index_regs_chk.sv
module ep_index_regs_chk
  import ep_regs_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int IDX_W  = 4,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        bus_addr,
  input logic              bus_we,
  input logic [DW-1:0]     bus_rdata,
  input logic [NUM_EP-1:0] out_rx_stb,
  input logic [NUM_EP-1:0] in_free_stb,
  input logic [NUM_EP-1:0] out_rdy_o,
  input logic [NUM_EP-1:0] in_rdy_o,
  input logic              irq_o,
  input logic [IDX_W-1:0]  idx_q,
  input logic [NUM_EP-1:0] in_en_q,
  input logic [NUM_EP-1:0] out_en_q
);

  logic en_wr;
  assign en_wr = bus_we && (bus_addr == A_IN_EN || bus_addr == A_OUT_EN);

  p_oob_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(idx_q) >= NUM_EP && bus_addr >= A_CSR1) |-> bus_rdata == '0);

  p_irq_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past((|out_rx_stb) || (|in_free_stb) || en_wr));

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    p_rx_sets_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_rx_stb[i] |=> out_rdy_o[i]);

    p_ready_rise_from_hw_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_rdy_o[i]) |-> $past(out_rx_stb[i]));

    p_free_clears_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_free_stb[i] |=> !in_rdy_o[i]);

    p_free_raises_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_free_stb[i] && in_en_q[i] && !en_wr) |=> irq_o);

    p_rx_raises_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_rx_stb[i] && out_en_q[i] && !en_wr) |=> irq_o);
  end

endmodule

bind ep_index_regs ep_index_regs_chk #(
  .NUM_EP (NUM_EP),
  .IDX_W  (IDX_W),
  .DW     (DW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_rdata   (bus_rdata),
  .out_rx_stb  (out_rx_stb),
  .in_free_stb (in_free_stb),
  .out_rdy_o   (out_rdy_o),
  .in_rdy_o    (in_rdy_o),
  .irq_o       (irq_o),
  .idx_q       (idx_q),
  .in_en_q     (in_en),
  .out_en_q    (out_en)
);

// File: tb/test_ep_index_regs.sv
module test_ep_index_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  out_rx_stb = '0;
  logic [27:0] out_rx_len = '0;
  logic [3:0]  in_free_stb = '0;
  logic [3:0]  out_rdy_o, in_rdy_o, dma_en_o;
  logic        irq_o;

  always #4 clk = ~clk;

  ep_index_regs i_ep_index_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_rx_stb(out_rx_stb),
    .out_rx_len(out_rx_len), .in_free_stb(in_free_stb), .out_rdy_o(out_rdy_o),
    .in_rdy_o(in_rdy_o), .dma_en_o(dma_en_o), .irq_o(irq_o)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [3:0] m_idx, m_out, m_in, m_dma, m_ien, m_oen, m_ist, m_ost;
  logic [6:0] m_cnt [4];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_write(logic [2:0] a, logic [7:0] d);
    case (a)
      3'd0: m_idx = d[3:0];
      3'd1: m_ien = d[3:0];
      3'd2: m_oen = d[3:0];
      3'd3: m_ist = m_ist & ~d[3:0];
      3'd4: m_ost = m_ost & ~d[3:0];
      3'd5: if (m_idx < 4) begin
              if (!d[0]) m_out[m_idx[1:0]] = 1'b0;
              m_in[m_idx[1:0]] = d[1];
            end
      3'd6: if (m_idx < 4) m_dma[m_idx[1:0]] = d[0];
      default: ;
    endcase
  endtask

  task automatic model_events(logic [3:0] rxm, logic [27:0] lens, logic [3:0] frm);
    for (int i = 0; i < 4; i++) begin
      if (rxm[i]) begin
        m_out[i] = 1'b1;
        m_ost[i] = 1'b1;
        m_cnt[i] = lens[i*7 +: 7];
      end
      if (frm[i]) begin
        m_in[i]  = 1'b0;
        m_ist[i] = 1'b1;
      end
    end
  endtask

  // One clock cycle with optional write and strobes applied together
  task automatic cycle(logic we, logic [2:0] a, logic [7:0] d,
                       logic [3:0] rxm, logic [27:0] lens, logic [3:0] frm);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    out_rx_stb = rxm; out_rx_len = lens; in_free_stb = frm;
    @(negedge clk);
    bus_we = 1'b0; out_rx_stb = '0; in_free_stb = '0;
    if (we) model_write(a, d);
    model_events(rxm, lens, frm);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    cycle(1'b1, a, d, 4'h0, 28'h0, 4'h0);
  endtask

  task automatic rd(string req, logic [2:0] a, logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(req, {24'h0, bus_rdata}, {24'h0, exp});
  endtask

  task automatic check_all(string req);
    logic [3:0] saved;
    saved = m_idx;
    chk(req, {28'h0, out_rdy_o}, {28'h0, m_out});
    chk(req, {28'h0, in_rdy_o},  {28'h0, m_in});
    chk(req, {28'h0, dma_en_o},  {28'h0, m_dma});
    chk(req, {31'h0, irq_o}, {31'h0, (|(m_ist & m_ien)) | (|(m_ost & m_oen))});
    rd(req, 3'd1, {4'h0, m_ien});
    rd(req, 3'd2, {4'h0, m_oen});
    rd(req, 3'd3, {4'h0, m_ist});
    rd(req, 3'd4, {4'h0, m_ost});
    for (int j = 0; j < 16; j++) begin
      wr(3'd0, 8'(j));
      rd("R2", 3'd0, 8'(j));
      if (j < 4) begin
        rd(req, 3'd5, {6'h0, m_in[j], m_out[j]});
        rd(req, 3'd6, {7'h0, m_dma[j]});
        rd(req, 3'd7, {1'b0, m_cnt[j]});
      end else begin
        rd("R3", 3'd5, 8'h0);
        rd("R3", 3'd6, 8'h0);
        rd("R3", 3'd7, 8'h0);
      end
    end
    wr(3'd0, {4'h0, saved});
  endtask

  function automatic logic [27:0] lens_for(int k);
    logic [27:0] v;
    for (int i = 0; i < 4; i++) v[i*7 +: 7] = 7'((k * 13 + i * 29 + 5) % 128);
    return v;
  endfunction

  initial begin
    m_idx = 0; m_out = 0; m_in = 0; m_dma = 0;
    m_ien = 0; m_oen = 0; m_ist = 0; m_ost = 0;
    for (int i = 0; i < 4; i++) m_cnt[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_all("R1");

    // R4, R8: receive strobes on each endpoint and on combinations
    for (int k = 1; k < 16; k++) begin
      cycle(1'b0, 3'd0, 8'h0, 4'(k), lens_for(k), 4'h0);
      chk("R4", {28'h0, out_rdy_o}, {28'h0, m_out});
    end
    check_all("R4");

    // R8: free strobes set IN pending, clear IN ready
    for (int i = 0; i < 4; i++) begin
      wr(3'd0, 8'(i));
      wr(3'd5, 8'h3);
    end
    cycle(1'b0, 3'd0, 8'h0, 4'h0, 28'h0, 4'b0101);
    check_all("R8");

    // R5: writing 1 to OUT ready bit has no effect; 0 clears
    wr(3'd0, 8'd2);
    wr(3'd5, 8'h1);
    rd("R5", 3'd5, {6'h0, m_in[2], m_out[2]});
    wr(3'd5, 8'h0);
    rd("R5", 3'd5, 8'h0);
    check_all("R5");

    // R6: every CSR1 value on every endpoint
    for (int i = 0; i < 4; i++) begin
      wr(3'd0, 8'(i));
      for (int v = 0; v < 4; v++) begin
        cycle(1'b0, 3'd0, 8'h0, 4'(1 << i), lens_for(v + 20), 4'h0);
        wr(3'd5, 8'(v));
        rd("R6", 3'd5, {6'h0, m_in[i], m_out[i]});
        chk("R6", {28'h0, in_rdy_o}, {28'h0, m_in});
      end
    end

    // R7: DMA enable patterns across endpoints
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 4; i++) begin
        wr(3'd0, 8'(i));
        wr(3'd6, {7'h0, p[i]});
      end
      chk("R7", {28'h0, dma_en_o}, {28'h0, 4'(p)});
    end
    check_all("R7");

    // R3: writes with out-of-range selector change nothing
    for (int j = 4; j < 16; j++) begin
      wr(3'd0, 8'(j));
      wr(3'd5, 8'h2);
      wr(3'd6, 8'h1);
      wr(3'd5, 8'h0);
      chk("R3", {24'h0, out_rdy_o, in_rdy_o}, {24'h0, m_out, m_in});
    end
    check_all("R3");

    // R9: pending patterns against all enable combinations
    for (int p = 0; p < 16; p++) begin
      wr(3'd3, 8'hF);
      wr(3'd4, 8'hF);
      cycle(1'b0, 3'd0, 8'h0, 4'(p), lens_for(p), ~4'(p));
      for (int e = 0; e < 16; e++) begin
        wr(3'd1, 8'(e));
        wr(3'd2, 8'(15 - e));
        chk("R9", {31'h0, irq_o},
            {31'h0, (|(m_ist & m_ien)) | (|(m_ost & m_oen))});
      end
    end
    check_all("R9");

    // R8: partial write-one-to-clear, writing 0 keeps bits
    cycle(1'b0, 3'd0, 8'h0, 4'hF, lens_for(3), 4'hF);
    wr(3'd3, 8'h0);
    wr(3'd4, 8'h5);
    wr(3'd3, 8'hA);
    rd("R8", 3'd3, {4'h0, m_ist});
    rd("R8", 3'd4, {4'h0, m_ost});
    check_all("R8");

    // Same-cycle conflicts
    wr(3'd0, 8'd1);
    cycle(1'b1, 3'd5, 8'h0, 4'b0010, lens_for(7), 4'h0);
    chk("R5", {31'h0, out_rdy_o[1]}, 32'h1);
    wr(3'd5, 8'h2);
    cycle(1'b1, 3'd5, 8'h2, 4'h0, 28'h0, 4'b0010);
    chk("R6", {31'h0, in_rdy_o[1]}, 32'h0);
    cycle(1'b1, 3'd4, 8'hF, 4'b1000, lens_for(9), 4'h0);
    rd("R8", 3'd4, 8'h08);
    cycle(1'b1, 3'd3, 8'hF, 4'h0, 28'h0, 4'b0100);
    rd("R8", 3'd3, 8'h04);
    check_all("R8");

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule